// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Per-Pin Byte Access

This block is a register-mapped general-purpose I/O controller for a set of 32-pin ports (eight by default, 256 pins). Pin number n is port × 32 + bit. Every pin owns one byte of the address space at byte offset n from the block base. Software can therefore set, clear or sample a single pin with one byte access and never needs a read-modify-write. Direction is held in one packed 32-bit word per port, placed at byte offset 0x2000 + 4 × port.

The bus is 32 bits wide with a byte address and four byte enables. A write is accepted in the cycle it is presented. A read returns its data in the next cycle. The block drives an output-enable vector from the direction bits and an output-value vector from the per-pin output latches. It samples the pad input vector through a two-flop synchronizer. When a pin is an input, a read of its byte returns the synchronized pad level. When it is an output, the read returns its own latch.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every direction bit and every output latch is 0, so `pin_oe` and `pin_out` are all zero, `bus_rdata` is zero and every direction word reads back as zero.
- R2: A write to a data word covering pins 4w..4w+3 (byte address 4w, below the pin count) updates pin 4w+k from byte lane k only when `bus_be[k]` is 1. The latch becomes 1 if the lane byte is nonzero and 0 if the byte is zero. Pins on lanes whose enable is 0 keep their value.
- R3: The effect of a data write is visible on `pin_out` at the clock edge that accepts the write.
- R4: A write to byte address 0x2000 + 4p sets the direction of pin 32p+b from `bus_wdata[b]`, and lane k only updates bits 8k..8k+7 when `bus_be[k]` is 1. A direction bit of 1 means output, and it appears on `pin_oe[32p+b]`.
- R5: A read of byte address 0x2000 + 4p returns the direction word of port p on `bus_rdata` in the cycle after `bus_re`.
- R6: A read of a data word returns, in byte lane k, exactly 0x00 or 0x01 for pin 4w+k. The value comes from the output latch when the pin's direction bit is 1. Otherwise it is the pad level from `pin_in` after two synchronizer flops.
- R7: An access to any other address reads as zero and its write changes no direction bit and no latch.
- R8: When a read and a write target the same location in the same cycle, the read returns the state from before the write.
- R9: `bus_rdata` is zero in every cycle that does not follow a cycle with `bus_re` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte address of the access, word aligned |
| bus_we | input | 1 | Write strobe, accepted in the same cycle |
| bus_re | input | 1 | Read strobe, data returned next cycle |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NPORT×32 | Pad input levels, asynchronous |
| pin_oe | output | NPORT×32 | Output enable per pin (direction bits) |
| pin_out | output | NPORT×32 | Output value per pin (latches) |

## Verification
A read and a write can land on the same data word or direction word in one cycle. The bench provokes this by raising `bus_re` and `bus_we` together on one address, with a value that differs from the stored one. The returned word must equal the bench model's state from before the write, and a second read must show the new value. A pin can also have its direction changed while its pad level differs from its latch. The bench judges this by sweeping all data words after each direction change and comparing each byte against the model's latch-or-pad choice.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int G_NPORT = 8;
    localparam int G_PORTW = 32;
    localparam int G_AW    = 14;
    localparam int G_DW    = 32;
    localparam int G_NLANE = G_DW / 8;
    localparam logic [G_AW-1:0] G_DIR_BASE = 14'h2000;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_DATA = 2'd1,
        RG_DIR  = 2'd2
    } region_e;

    function automatic logic [7:0] level_byte(input logic v);
        return {7'b0, v};
    endfunction
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int NPORT = G_NPORT
) (
    input  logic [G_AW-1:0] addr,
    output region_e         region,
    output logic [$clog2(NPORT*G_PORTW)-1:0] pin_base,
    output logic [$clog2(NPORT)-1:0]         port
);
    localparam int NPIN = NPORT * G_PORTW;
    localparam int PIW  = $clog2(NPIN);
    localparam int PTW  = $clog2(NPORT);
    localparam logic [G_AW-1:0] NPIN_A  = NPIN[G_AW-1:0];
    localparam logic [G_AW-3:0] DIRW    = G_DIR_BASE[G_AW-1:2];
    localparam logic [G_AW-3:0] NPORT_W = NPORT[G_AW-3:0];

    logic [G_AW-3:0] waddr;
    logic [G_AW-3:0] doff;

    always_comb begin
        waddr    = addr[G_AW-1:2];
        doff     = waddr - DIRW;
        pin_base = {addr[PIW-1:2], 2'b00};
        port     = doff[PTW-1:0];
        if (addr < NPIN_A)
            region = RG_DATA;
        else if (waddr >= DIRW && doff < NPORT_W)
            region = RG_DIR;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PW = G_PORTW,
    parameter int SW = $clog2(G_PORTW / G_NLANE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dir_we,
    input  logic               data_we,
    input  logic [SW-1:0]      data_sub,
    input  logic [G_NLANE-1:0] be,
    input  logic [G_DW-1:0]    wdata,
    output logic [PW-1:0]      dir_q,
    output logic [PW-1:0]      lat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            for (int b = 0; b < PW; b++) begin
                if (dir_we && be[b / 8])
                    dir_q[b] <= wdata[b];
                if (data_we && data_sub == SW'(b / G_NLANE) && be[b % G_NLANE])
                    lat_q[b] <= |wdata[8*(b % G_NLANE) +: 8];
            end
        end
    end
endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
    import gpio_pkg::*;
#(
    parameter int NPORT = G_NPORT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [G_AW-1:0]          bus_addr,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [G_NLANE-1:0]       bus_be,
    input  logic [G_DW-1:0]          bus_wdata,
    output logic [G_DW-1:0]          bus_rdata,
    input  logic [NPORT*G_PORTW-1:0] pin_in,
    output logic [NPORT*G_PORTW-1:0] pin_oe,
    output logic [NPORT*G_PORTW-1:0] pin_out
);
    localparam int NPIN = NPORT * G_PORTW;
    localparam int PIW  = $clog2(NPIN);
    localparam int PTW  = $clog2(NPORT);
    localparam int SW   = $clog2(G_PORTW / G_NLANE);
    localparam int PSH  = $clog2(G_PORTW);

    region_e          region;
    logic [PIW-1:0]   pin_base;
    logic [PTW-1:0]   port;
    logic [NPIN-1:0]  dir_flat;
    logic [NPIN-1:0]  lat_flat;
    logic [NPIN-1:0]  in_sync;
    logic [NPIN-1:0]  level;
    logic [G_DW-1:0]  rd_next;

    gpio_decode #(.NPORT(NPORT)) u_dec (
        .addr     (bus_addr),
        .region   (region),
        .pin_base (pin_base),
        .port     (port)
    );

    gpio_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_port #(.PW(G_PORTW), .SW(SW)) u_port (
            .clk      (clk),
            .rst      (rst),
            .dir_we   (bus_we && region == RG_DIR && port == PTW'(p)),
            .data_we  (bus_we && region == RG_DATA && pin_base[PIW-1:PSH] == PTW'(p)),
            .data_sub (pin_base[PSH-1:2]),
            .be       (bus_be),
            .wdata    (bus_wdata),
            .dir_q    (dir_flat[p*G_PORTW +: G_PORTW]),
            .lat_q    (lat_flat[p*G_PORTW +: G_PORTW])
        );
    end

    assign level   = (dir_flat & lat_flat) | (~dir_flat & in_sync);
    assign pin_oe  = dir_flat;
    assign pin_out = lat_flat;

    always_comb begin
        rd_next = '0;
        case (region)
            RG_DATA: begin
                for (int k = 0; k < G_NLANE; k++)
                    rd_next[8*k +: 8] = level_byte(level[pin_base + PIW'(k)]);
            end
            RG_DIR:  rd_next = dir_flat[{port, {PSH{1'b0}}} +: G_PORTW];
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_next;
        else
            bus_rdata <= '0;
    end
endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk
    import gpio_pkg::*;
#(
    parameter int NPORT = G_NPORT
) (
    input logic                     clk,
    input logic                     rst,
    input logic [G_AW-1:0]          bus_addr,
    input logic                     bus_we,
    input logic                     bus_re,
    input logic [G_NLANE-1:0]       bus_be,
    input logic [G_DW-1:0]          bus_rdata,
    input logic [NPORT*G_PORTW-1:0] pin_oe,
    input logic [NPORT*G_PORTW-1:0] pin_out
);
    localparam int NPIN = NPORT * G_PORTW;
    localparam logic [G_AW-1:0] NPIN_A = NPIN[G_AW-1:0];
    localparam logic [G_AW-1:0] DIR_END = G_DIR_BASE + 14'(4 * NPORT);

    logic is_data, is_dir, rst_q, data_rd_q;
    assign is_data = bus_addr < NPIN_A;
    assign is_dir  = bus_addr >= G_DIR_BASE && bus_addr < DIR_END;

    always_ff @(posedge clk) begin
        rst_q     <= rst;
        data_rd_q <= bus_re && is_data;
    end

    // R1: state is cleared by reset
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_reset_clear: assert (pin_oe == '0 && pin_out == '0 && bus_rdata == '0);
    end

    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !is_data && !is_dir) |=> ($stable(pin_oe) && $stable(pin_out)));

    a_r2_no_lane_no_change: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_be == '0) |=> ($stable(pin_oe) && $stable(pin_out)));

    a_r4_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_oe) && $stable(pin_out)));

    a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0));

    // R6: data bytes are 0x00 or 0x01
    always_ff @(posedge clk) begin
        if (!rst && data_rd_q)
            a_r6_byte_is_level: assert ((bus_rdata & 32'hFEFE_FEFE) == '0);
    end
endmodule

bind gpio_ctl gpio_ctl_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio_ctl_bench.sv
module gpio_ctl_bench;
    localparam int NP   = 8;
    localparam int NPIN = NP * 32;

    logic            clk = 0;
    logic            rst = 1;
    logic [13:0]     bus_addr = '0;
    logic            bus_we = 0, bus_re = 0;
    logic [3:0]      bus_be = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_oe, pin_out;

    logic [NPIN-1:0] m_lat = '0, m_dir = '0;
    int total = 0, bad = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    gpio_ctl #(.NPORT(NP)) u_gpio_ctl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
        if (a < 14'(NPIN)) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) m_lat[{a[7:2], 2'(k)}] = (d[8*k +: 8] != 0);
        end else if (a >= 14'h2000 && a < 14'h2000 + 14'(4*NP)) begin
            for (int b = 0; b < 32; b++)
                if (be[b/8]) m_dir[32*((a - 14'h2000) >> 2) + b] = d[b];
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [13:0] a);
        logic [31:0] r = '0;
        if (a < 14'(NPIN)) begin
            for (int k = 0; k < 4; k++) begin
                int i = 4 * int'(a[13:2]) + k;
                r[8*k] = m_dir[i] ? m_lat[i] : pin_in[i];
            end
        end else if (a >= 14'h2000 && a < 14'h2000 + 14'(4*NP))
            r = m_dir[32*((a - 14'h2000) >> 2) +: 32];
        return r;
    endfunction

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        model_wr(a, d, be);
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1;
        @(negedge clk);
        bus_re = 0;
        d = bus_rdata;
    endtask

    task automatic sweep_data(input string tag);
        for (int w = 0; w < NPIN / 4; w++) begin
            logic [31:0] e;
            e = exp_word(14'(4 * w));
            rd(14'(4 * w), got);
            chk(got == e, tag, got, e);
        end
    endtask

    task automatic set_pads(input int seed);
        for (int i = 0; i < NPIN; i++) pin_in[i] = ((i * 13 + seed) % 7) < 3;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(pin_oe == '0, "R1 pin_oe", pin_oe, '0);
        chk(pin_out == '0, "R1 pin_out", pin_out, '0);
        chk(bus_rdata == '0, "R1 rdata", bus_rdata, '0);
        for (int p = 0; p < NP; p++) begin
            rd(14'h2000 + 14'(4 * p), got);
            chk(got == '0, "R1 dir word", got, '0);
        end

        // R6: all pins inputs, pads visible after synchronizer
        set_pads(1);
        sweep_data("R6 input pads");

        // R2/R3: single-lane writes to every pin, other lanes hold junk
        for (int i = 0; i < NPIN; i++) begin
            logic [7:0]  v;
            logic [31:0] d;
            v = (i % 3 == 0) ? 8'h00 : (i % 3 == 1) ? 8'h01 : 8'(i | 8'h80);
            d = 32'hA5A5_A5A5;
            d[8*(i%4) +: 8] = v;
            wr(14'(i & ~3), d, 4'(1 << (i % 4)));
            chk(pin_out == m_lat, "R3 pin_out after byte write", pin_out, m_lat);
        end

        // R2: multi-lane writes sweeping every enable pattern
        for (int w = 0; w < 64; w++) begin
            wr(14'(4 * w), 32'h40_00_FF_00 ^ {8'(w), 8'(w * 3), 8'(w * 5), 8'(w & 1)}, 4'(w % 16));
            chk(pin_out == m_lat, "R2 lane enables", pin_out, m_lat);
        end

        // R4/R5: direction words with byte-enable sweep
        for (int p = 0; p < NP; p++) begin
            for (int be = 0; be < 16; be += 5) begin
                wr(14'h2000 + 14'(4 * p), 32'h9C3A_5E71 ^ (32'h0101_0101 * p * (be + 1)), 4'(be));
                chk(pin_oe == m_dir, "R4 pin_oe", pin_oe, m_dir);
            end
            rd(14'h2000 + 14'(4 * p), got);
            chk(got == exp_word(14'h2000 + 14'(4 * p)), "R5 dir readback", got, exp_word(14'h2000 + 14'(4 * p)));
        end

        // R6: mixed directions, two pad patterns
        sweep_data("R6 mixed dir");
        set_pads(4);
        sweep_data("R6 mixed dir new pads");

        // R7: unmapped addresses
        begin
            logic [13:0] um [4] = '{14'h0100, 14'h1FFC, 14'h2000 + 14'(4*NP), 14'h3FFC};
            for (int j = 0; j < 4; j++) begin
                wr(um[j], 32'hFFFF_FFFF, 4'hF);
                chk(pin_oe == m_dir && pin_out == m_lat, "R7 unmapped write", {pin_oe ^ m_dir}, '0);
                rd(um[j], got);
                chk(got == '0, "R7 unmapped read", got, '0);
            end
        end

        // R8: same-cycle read and write on a data word and a direction word
        begin
            logic [13:0] ta [2] = '{14'h0014, 14'h2008};
            for (int j = 0; j < 2; j++) begin
                logic [31:0] old_e, nd;
                old_e = exp_word(ta[j]);
                nd = ~m_dir[64 +: 32] ^ 32'h0100_0001;
                if (j == 0) nd = {8'h00, 8'h11, 8'h00, 8'h22} ^ {8'h00, 8'(m_lat[23]), 8'h00, 8'(m_lat[20])};
                @(negedge clk);
                bus_addr = ta[j]; bus_wdata = nd; bus_be = 4'hF; bus_we = 1; bus_re = 1;
                @(negedge clk);
                bus_we = 0; bus_re = 0;
                got = bus_rdata;
                chk(got == old_e, "R8 read returns pre-write", got, old_e);
                model_wr(ta[j], nd, 4'hF);
                // R9: no read in the previous cycle
                @(negedge clk);
                chk(bus_rdata == '0, "R9 idle rdata", bus_rdata, '0);
                rd(ta[j], got);
                chk(got == exp_word(ta[j]), "R8 read after write", got, exp_word(ta[j]));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule